// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit logical address into a physical address. It reads translation descriptors from memory and works on one request at a time. A requester hands it an address through a valid/ready pair. The walker takes the table origin from a base input and fetches the first-level descriptor through a single valid/ready read port. What that descriptor holds decides whether the walk ends there (a 1 MB section) or goes on to a second read. The second-level descriptor then picks a 64 KB large page or a 4 KB small page.

Each page size keeps a different number of low logical bits as the offset. The result is a physical address or a fault flag that names the level that failed. It stays on the response port until the requester takes it.

A table descriptor is a 32-bit word. Bits [1:0] give its kind, and the upper bits carry either a physical base or a pointer to the next table.

Top module: `xlat_walker`

## Requirements
- R1: `reqReady` is high only while the walker is idle. A request offered while a walk or an unaccepted result is pending is not taken and starts no memory read.
- R2: The first read goes to address {tableBase[17:0], logical[31:20], 2'b00}, using the base value present when the request was accepted.
- R3: A first-level descriptor with bits [1:0] = 2'b10 is a section. The walk ends after that single read with physical address {descriptor[31:20], logical[19:0]}.
- R4: A first-level descriptor with bits [1:0] = 2'b01 points to a second-level table. The second read goes to {descriptor[31:10], logical[19:12], 2'b00}.
- R5: A second-level descriptor with bits [1:0] = 2'b01 is a large page, giving physical address {descriptor[31:16], logical[15:0]}.
- R6: A second-level descriptor with bits [1:0] = 2'b10 is a small page, giving physical address {descriptor[31:12], logical[11:0]}.
- R7: A first-level kind of 2'b00 or 2'b11 gives `rspFault` = 1 with `rspFaultLvl` = 0 and `rspPaddr` = 0, and no second read is issued.
- R8: A second-level kind of 2'b00 or 2'b11 gives `rspFault` = 1 with `rspFaultLvl` = 1 and `rspPaddr` = 0.
- R9: Once `rspValid` rises, it and the result fields hold steady until a cycle with `rspReady` high. After that cycle the walker is idle again.
- R10: While `memReqValid` is high and `memReqReady` is low, the read request stays asserted and `memAddr` does not change.
- R11: After reset, `reqReady` = 1, `rspValid` = 0 and `memReqValid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A logical address is offered |
| reqReady | output | 1 | Walker idle, request taken this cycle |
| reqVaddr | input | 32 | Logical address to translate |
| tableBase | input | 18 | Upper bits [31:14] of the first-level table origin |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the read request |
| memAddr | output | 32 | Byte address of the descriptor |
| memRspValid | input | 1 | Descriptor word returned |
| memRspData | input | 32 | Descriptor word |
| rspValid | output | 1 | Translation result available |
| rspReady | input | 1 | Requester takes the result |
| rspFault | output | 1 | The walk ended in a fault |
| rspFaultLvl | output | 1 | Failing level: 0 first, 1 second |
| rspPaddr | output | 32 | Translated physical address, zero on fault |

## Verification
Two things can happen in the same cycle: a finished result that the requester has not yet taken, and a fresh request already waiting at the input. The bench provokes this by keeping `rspReady` low for several cycles after `rspValid` rises while it raises `reqValid` with a different address. In each of those cycles it checks that `reqReady` stays low, that the result does not move, and that no extra descriptor read appears. Memory back-pressure on every third vector overlaps the wait for the request handshake with a held address.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int ADDR_W    = 32;
  localparam int L1_IDX_W  = 12;
  localparam int L2_IDX_W  = 8;
  localparam int SEC_OFF_W = 20;
  localparam int LRG_OFF_W = 16;
  localparam int SML_OFF_W = 12;
  localparam int BASE_W    = ADDR_W - L1_IDX_W - 2;
  localparam int PTR_W     = ADDR_W - L2_IDX_W - 2;

  localparam logic [1:0] KIND_FAULT   = 2'b00;
  localparam logic [1:0] KIND_TABLE   = 2'b01;
  localparam logic [1:0] KIND_SECTION = 2'b10;
  localparam logic [1:0] KIND_LARGE   = 2'b01;
  localparam logic [1:0] KIND_SMALL   = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1REQ, ST_L1WAIT, ST_L2REQ, ST_L2WAIT, ST_DONE
  } walkState_t;

  typedef struct packed {
    logic loadReq;
    logic loadPtr;
    logic loadRes;
    logic selL2;
  } walkStrobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic [1:0]  descKind,
  output logic        rspValid,
  input  logic        rspReady,
  output walkStrobe_t strobe
);
  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_L1REQ;
      ST_L1REQ:  if (memReqReady) stateNext = ST_L1WAIT;
      ST_L1WAIT: if (memRspValid)
                   stateNext = (descKind == KIND_TABLE) ? ST_L2REQ : ST_DONE;
      ST_L2REQ:  if (memReqReady) stateNext = ST_L2WAIT;
      ST_L2WAIT: if (memRspValid) stateNext = ST_DONE;
      ST_DONE:   if (rspReady) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_L1REQ) || (state == ST_L2REQ);
  assign rspValid    = (state == ST_DONE);

  always_comb begin
    strobe.loadReq = (state == ST_IDLE) && reqValid;
    strobe.selL2   = (state == ST_L2REQ) || (state == ST_L2WAIT);
    strobe.loadPtr = (state == ST_L1WAIT) && memRspValid && (descKind == KIND_TABLE);
    strobe.loadRes = ((state == ST_L1WAIT) && memRspValid && (descKind != KIND_TABLE))
                   || ((state == ST_L2WAIT) && memRspValid);
  end

  // R1: an accepted request moves straight into a read and closes the input
  p_accept_starts_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (memReqValid && !reqReady));

  // R1: no new request is taken while a result waits
  p_busy_blocks_input_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> !reqReady);

  // R9: result presence persists until taken
  p_result_waits_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // R10: a stalled read request is not withdrawn
  p_read_persists_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);
endmodule

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   reqVaddr,
  input  logic [BASE_W-1:0]   tableBase,
  input  logic [ADDR_W-1:0]   memRspData,
  output logic [1:0]          descKind,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                rspFault,
  output logic                rspFaultLvl,
  output logic [ADDR_W-1:0]   rspPaddr
);
  logic [ADDR_W-1:0] vaddrQ;
  logic [BASE_W-1:0] baseQ;
  logic [PTR_W-1:0]  ptrQ;
  logic [ADDR_W-1:0] paddrNext;
  logic              faultNext;
  logic              unusedDescBits;

  assign descKind       = memRspData[1:0];
  assign unusedDescBits = ^memRspData[PTR_W+1:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ <= '0;
      baseQ  <= '0;
      ptrQ   <= '0;
    end else begin
      if (strobe.loadReq) begin
        vaddrQ <= reqVaddr;
        baseQ  <= tableBase;
      end
      if (strobe.loadPtr) ptrQ <= memRspData[ADDR_W-1 -: PTR_W];
    end
  end

  always_comb begin
    if (strobe.selL2)
      memAddr = {ptrQ, vaddrQ[SEC_OFF_W-1 -: L2_IDX_W], 2'b00};
    else
      memAddr = {baseQ, vaddrQ[ADDR_W-1 -: L1_IDX_W], 2'b00};
  end

  always_comb begin
    paddrNext = '0;
    faultNext = 1'b1;
    if (!strobe.selL2) begin
      if (descKind == KIND_SECTION) begin
        paddrNext = {memRspData[ADDR_W-1:SEC_OFF_W], vaddrQ[SEC_OFF_W-1:0]};
        faultNext = 1'b0;
      end
    end else begin
      if (descKind == KIND_LARGE) begin
        paddrNext = {memRspData[ADDR_W-1:LRG_OFF_W], vaddrQ[LRG_OFF_W-1:0]};
        faultNext = 1'b0;
      end else if (descKind == KIND_SMALL) begin
        paddrNext = {memRspData[ADDR_W-1:SML_OFF_W], vaddrQ[SML_OFF_W-1:0]};
        faultNext = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr    <= '0;
      rspFault    <= 1'b0;
      rspFaultLvl <= 1'b0;
    end else if (strobe.loadRes) begin
      rspPaddr    <= paddrNext;
      rspFault    <= faultNext;
      rspFaultLvl <= strobe.selL2;
    end
  end

  // R7, R8: a faulting result never carries an address
  p_fault_clears_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRes && faultNext) |=> (rspFault && rspPaddr == '0));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVaddr,
  input  logic [17:0] tableBase,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        rspValid,
  input  logic        rspReady,
  output logic        rspFault,
  output logic        rspFaultLvl,
  output logic [31:0] rspPaddr
);
  walkStrobe_t strobe;
  logic [1:0]  descKind;

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .descKind(descKind),
    .rspValid(rspValid), .rspReady(rspReady),
    .strobe(strobe)
  );

  xlat_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqVaddr(reqVaddr), .tableBase(tableBase),
    .memRspData(memRspData), .descKind(descKind),
    .memAddr(memAddr),
    .rspFault(rspFault), .rspFaultLvl(rspFaultLvl), .rspPaddr(rspPaddr)
  );

  // R10: the address of a stalled read is held
  p_addr_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memAddr));

  // R9: result fields hold until taken
  p_result_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> ($stable(rspPaddr) && $stable(rspFault) && $stable(rspFaultLvl)));
endmodule

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;
  localparam logic [17:0] BASE = 18'h2A5C0;
  localparam logic [21:0] L2PTR = 22'h000117;
  // fields: vaddr[67:36] fault[35] lvl[34] paddr[33:2] reads[1:0]
  localparam int NV = 9;
  localparam logic [67:0] VEC [NV] = '{
    {32'h001ABCDE, 1'b0, 1'b0, 32'h123ABCDE, 2'd1},  // R3 section
    {32'h00210ABC, 1'b0, 1'b0, 32'h5A5A0ABC, 2'd2},  // R5 large
    {32'h00220FED, 1'b0, 1'b0, 32'h87654FED, 2'd2},  // R6 small
    {32'h00230123, 1'b1, 1'b1, 32'h00000000, 2'd2},  // R8 kind 00
    {32'h00240456, 1'b1, 1'b1, 32'h00000000, 2'd2},  // R8 kind 11
    {32'h00312345, 1'b1, 1'b0, 32'h00000000, 2'd1},  // R7 kind 00
    {32'h00454321, 1'b1, 1'b0, 32'h00000000, 2'd1},  // R7 kind 11
    {32'h7FFFFFFF, 1'b0, 1'b0, 32'hABCFFFFF, 2'd1},  // R3 top offset
    {32'h00255555, 1'b1, 1'b1, 32'h00000000, 2'd2}   // R8 empty slot
  };

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqReady;
  logic [31:0] reqVaddr = 0;
  logic [17:0] tableBase = BASE;
  logic memReqValid, memReqReady = 1;
  logic [31:0] memAddr;
  logic memRspValid = 0;
  logic [31:0] memRspData = 0;
  logic rspValid, rspReady = 0, rspFault, rspFaultLvl;
  logic [31:0] rspPaddr;

  int checks = 0, errors = 0;
  int readCount = 0, holdErr = 0, stallSeen = 0, cyc = 0;
  logic stallMode = 0;
  logic [31:0] firstAddr = 0, secondAddr = 0;

  always #5 clk = ~clk;

  xlat_walker u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .tableBase(tableBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspFault(rspFault),
    .rspFaultLvl(rspFaultLvl), .rspPaddr(rspPaddr)
  );

  function automatic logic [31:0] memRead(input logic [31:0] a);
    memRead = 32'h0;
    if (a[31:14] == BASE) begin
      case (a[13:2])
        12'h001: memRead = 32'h12300002;
        12'h002: memRead = {L2PTR, 10'h001};
        12'h004: memRead = 32'hFFFFFFFF;
        12'h7FF: memRead = 32'hABC00002;
        default: memRead = 32'h0;
      endcase
    end else if (a[31:10] == L2PTR) begin
      case (a[9:2])
        8'h10:   memRead = 32'h5A5A0001;
        8'h20:   memRead = 32'h87654002;
        8'h40:   memRead = 32'h00000003;
        default: memRead = 32'h0;
      endcase
    end
  endfunction

  function automatic string tagOf(input logic f, input logic l, input logic [1:0] r, input logic [31:0] v);
    if (f) tagOf = l ? "R8" : "R7";
    else if (r == 2'd1) tagOf = "R3";
    else tagOf = (v[19:12] == 8'h10) ? "R5" : "R6";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory model: request sampled just before each rising edge, answer one cycle later
  initial begin
    logic pending = 0;
    logic [31:0] pendAddr = 0, heldAddr = 0;
    logic holdSeen = 0;
    forever begin
      @(negedge clk);
      cyc++;
      memRspValid = pending;
      memRspData  = pending ? memRead(pendAddr) : 32'h0;
      pending = 0;
      memReqReady = stallMode ? (cyc % 3 == 0) : 1'b1;
      #4;
      if (rstN && memReqValid) begin
        if (holdSeen && memAddr != heldAddr) holdErr++;
        if (!memReqReady) begin
          heldAddr = memAddr; holdSeen = 1; stallSeen++;
        end else begin
          holdSeen = 0; pending = 1; pendAddr = memAddr;
          if (readCount == 0) firstAddr = memAddr; else secondAddr = memAddr;
          readCount++;
        end
      end
    end
  end

  task automatic runVec(input logic [67:0] v, input int hold);
    logic [31:0] va, ep, snap;
    logic ef, el;
    logic [1:0] er;
    int rc;
    string tg;
    va = v[67:36]; ef = v[35]; el = v[34]; ep = v[33:2]; er = v[1:0];
    tg = tagOf(ef, el, er, va);
    @(negedge clk);
    readCount = 0;
    reqValid = 1; reqVaddr = va;
    @(negedge clk);
    reqValid = 0;
    while (!rspValid) @(negedge clk);
    rc = readCount;
    snap = rspPaddr;
    for (int k = 0; k < hold; k++) begin
      reqValid = 1; reqVaddr = ~va;
      check(!reqReady, "R1", "request taken while result pending", {31'h0, reqReady}, 32'h0);
      @(negedge clk);
      check(rspValid && rspPaddr == snap, "R9", "result not held", rspPaddr, snap);
    end
    reqValid = 0;
    check(readCount == rc, "R1", "extra read while busy", readCount, rc);
    check(rspFault == ef, tg, "fault flag", {31'h0, rspFault}, {31'h0, ef});
    if (ef) check(rspFaultLvl == el, tg, "fault level", {31'h0, rspFaultLvl}, {31'h0, el});
    check(rspPaddr == ep, tg, "physical address", rspPaddr, ep);
    check(readCount == int'(er), (er == 2'd1) ? "R7" : "R4", "read count", readCount, {30'h0, er});
    check(firstAddr == {BASE, va[31:20], 2'b00}, "R2", "first descriptor address",
          firstAddr, {BASE, va[31:20], 2'b00});
    if (er == 2'd2)
      check(secondAddr == {L2PTR, va[19:12], 2'b00}, "R4", "second descriptor address",
            secondAddr, {L2PTR, va[19:12], 2'b00});
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
    check(!rspValid && reqReady, "R9", "not idle after take", {31'h0, rspValid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R11
    check(reqReady && !rspValid && !memReqValid, "R11", "reset state",
          {29'h0, reqReady, rspValid, memReqValid}, 32'h4);
    for (int i = 0; i < NV; i++) begin
      stallMode = (i % 3 == 1);
      runVec(VEC[i], i % 3);
    end
    // R10: back-pressure seen and address held throughout
    check(stallSeen > 0, "R10", "stall exercised", stallSeen, 1);
    check(holdErr == 0, "R10", "address moved during stall", holdErr, 0);
    // R2: base sampled at accept, changed mid-walk
    stallMode = 1;
    @(negedge clk);
    readCount = 0;
    reqValid = 1; reqVaddr = 32'h001ABCDE;
    @(negedge clk);
    reqValid = 0; tableBase = 18'h00001;
    while (!rspValid) @(negedge clk);
    check(firstAddr == {BASE, 12'h001, 2'b00}, "R2", "base taken at accept",
          firstAddr, {BASE, 12'h001, 2'b00});
    check(rspPaddr == 32'h123ABCDE, "R3", "section under stall", rspPaddr, 32'h123ABCDE);
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
    tableBase = BASE;
    stallMode = 0;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule